// File: doc/BRIEF.md
# Up-Down PWM Compare Unit

This block drives a single PWM pin from a symmetric time base. A counter climbs from zero to a programmable period and then falls back to zero. While it runs, the counter is compared against an active compare value. A match while rising and a match while falling each trigger a programmable action on the pin. The counter reaching zero and reaching the period can also each trigger an action. Software programs the block through a single-cycle register port. That port holds the period, a shadowed compare value, an action word that applies at once, and a mode word.

The compare value passes from its shadow copy to the active copy only at counter boundaries. In the normal mode both the zero and the period boundary qualify. In the zero-only mode only the zero boundary does. Action-word writes are not shadowed. After a reconfiguration in zero-only mode, the first pulse can therefore mix the new actions with the old compare value and come out shorter. This is the intended behaviour, and it is specified below. Two such units running at one period can produce unequal dead times by giving one of them a compare value lowered by a delta.

The time base is a two-state machine. TB_UP moves to TB_DOWN when the count reaches the period. TB_DOWN moves to TB_UP when the count is at zero. The pin level is a second two-state machine. PWM_LO moves to PWM_HI on a winning set action. PWM_HI moves to PWM_LO on a winning clear action.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset the pin is low, the count is 0, the direction output shows counting up, and all four registers read 0.
- R2: With period P > 0 the count runs 0,1,...,P,P-1,...,1,0,1,... and spends exactly 2P clocks per cycle. With P = 0 the count stays at 0.
- R3: A compare match happens when the count equals an active compare value C with 1 <= C < P. It is an up match while counting up and a down match while counting down. The pin changes on the clock edge that ends the matching count.
- R4: Action word fields are: bits 1:0 for zero, bits 3:2 for period, bits 5:4 for up match, bits 7:6 for down match. Code 01 clears the pin, 10 sets it, and 00 or 11 does nothing. For example, 0x0090 sets on down match and clears on up match, and 0x0050 clears on both.
- R5: With mode bit 0 clear, the shadow compare is copied to the active compare at the edge that ends a zero count and at the edge that ends a period count.
- R6: With mode bit 0 set, the copy happens only at the zero count. A compare written before a period boundary therefore keeps the old value for the next down match.
- R7: A write to the action word takes effect on the next clock, with no shadowing.
- R8: When events coincide, the first event in the order compare, period, zero that carries a set or clear action decides the pin.
- R9: An active compare of 0, or of P or more, gives no match. The pin then keeps its level, with no pulse.
- R10: The register map is: address 0 period, 1 compare, 2 action word, 3 mode. Writes take one cycle with write enable and address. Reading address 1 returns the shadow compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address, used for both write and read |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr |
| cnt_out | output | W | Current time-base count |
| dir_up | output | 1 | High while the time base counts up |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench goes after the partial first pulse. In zero-only mode, an action word written just before the period boundary together with a new compare must give a 10-clock pulse and then a 12-clock pulse. A design that honoured the period load would give 12 both times. A design that shadowed the action word would give no pulse in that period. The bench also parks the compare out of range in the middle of a high phase, where a design that still matched would drop the pin. Finally, it makes zero and period coincide at period 0 to show that the period action wins. Duty counts across several mode and action patterns catch compare matches fired in the wrong direction or one clock off.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;

    typedef enum logic [1:0] {
        AQ_NONE = 2'b00,
        AQ_CLR  = 2'b01,
        AQ_SET  = 2'b10,
        AQ_RSVD = 2'b11
    } aq_code_t;

    typedef enum logic {
        TB_UP   = 1'b0,
        TB_DOWN = 1'b1
    } tb_state_t;

    typedef enum logic {
        PWM_LO = 1'b0,
        PWM_HI = 1'b1
    } pwm_state_t;

    localparam logic [1:0] ADDR_PRD  = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_ACT  = 2'd2;
    localparam logic [1:0] ADDR_MODE = 2'd3;

    function automatic logic aq_live(input aq_code_t c);
        return (c == AQ_SET) || (c == AQ_CLR);
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwm_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prd,
    output logic [W-1:0] cnt,
    output logic         dir_up,
    output logic         at_zero,
    output logic         at_prd
);
    localparam logic [W-1:0] ONE = W'(1);

    tb_state_t    state, nxt_state;
    logic [W-1:0] nxt_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TB_UP;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            TB_UP: begin
                if (cnt >= prd) begin
                    if (prd == '0) begin
                        nxt_cnt = '0;
                    end else begin
                        nxt_state = TB_DOWN;
                        nxt_cnt   = cnt - ONE;
                    end
                end else begin
                    nxt_cnt = cnt + ONE;
                end
            end
            TB_DOWN: begin
                if (cnt == '0) begin
                    nxt_state = TB_UP;
                    nxt_cnt   = (prd == '0) ? '0 : ONE;
                end else begin
                    nxt_cnt = cnt - ONE;
                end
            end
        endcase
    end

    always_comb begin
        dir_up  = (state == TB_UP);
        at_zero = (cnt == '0);
        at_prd  = (cnt == prd);
    end

endmodule

// File: rtl/pwm_cmp_shadow.sv
`timescale 1ns/1ps
module pwm_cmp_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         at_zero,
    input  logic         at_prd,
    input  logic         zero_only,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active
);
    logic load;

    always_comb load = at_zero || (at_prd && !zero_only);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_en) shadow <= wdata;
            if (load)  active <= shadow;
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
`timescale 1ns/1ps
module pwm_action_qual
    import pwm_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] aq_word,
    input  logic       ev_zero,
    input  logic       ev_prd,
    input  logic       ev_up,
    input  logic       ev_dn,
    output logic       pwm
);
    aq_code_t   c_zero, c_prd, c_up, c_dn, c_cmp, win;
    pwm_state_t state, nxt_state;

    always_comb begin
        c_zero = aq_code_t'(aq_word[1:0]);
        c_prd  = aq_code_t'(aq_word[3:2]);
        c_up   = aq_code_t'(aq_word[5:4]);
        c_dn   = aq_code_t'(aq_word[7:6]);
        c_cmp  = ev_up ? c_up : (ev_dn ? c_dn : AQ_NONE);
        if ((ev_up || ev_dn) && aq_live(c_cmp)) win = c_cmp;
        else if (ev_prd && aq_live(c_prd))      win = c_prd;
        else if (ev_zero && aq_live(c_zero))    win = c_zero;
        else                                    win = AQ_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PWM_LO;
        else        state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            PWM_LO: if (win == AQ_SET) nxt_state = PWM_HI;
            PWM_HI: if (win == AQ_CLR) nxt_state = PWM_LO;
        endcase
    end

    always_comb pwm = (state == PWM_HI);

endmodule

// File: rtl/pwm_cmp_unit.sv
`timescale 1ns/1ps
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic [W-1:0] cnt_out,
    output logic         dir_up,
    output logic         pwm_out
);
    logic [W-1:0] prd_q, act_q, mode_q;
    logic [W-1:0] cmp_shd, cmp_act, cnt;
    logic         at_zero, at_prd, cmp_ok, ev_up, ev_dn, cmp_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q  <= '0;
            act_q  <= '0;
            mode_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_PRD)  prd_q  <= reg_wdata;
            if (reg_addr == ADDR_ACT)  act_q  <= reg_wdata;
            if (reg_addr == ADDR_MODE) mode_q <= reg_wdata;
        end
    end

    always_comb cmp_wr = reg_wr && (reg_addr == ADDR_CMP);

    pwm_timebase #(.W(W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .prd    (prd_q),
        .cnt    (cnt),
        .dir_up (dir_up),
        .at_zero(at_zero),
        .at_prd (at_prd)
    );

    pwm_cmp_shadow #(.W(W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_wr),
        .wdata    (reg_wdata),
        .at_zero  (at_zero),
        .at_prd   (at_prd),
        .zero_only(mode_q[0]),
        .shadow   (cmp_shd),
        .active   (cmp_act)
    );

    always_comb begin
        cmp_ok = (cmp_act != '0) && (cmp_act < prd_q) && (cnt == cmp_act);
        ev_up  = cmp_ok && dir_up;
        ev_dn  = cmp_ok && !dir_up;
    end

    pwm_action_qual u_aq (
        .clk    (clk),
        .rst_n  (rst_n),
        .aq_word(act_q[7:0]),
        .ev_zero(at_zero),
        .ev_prd (at_prd),
        .ev_up  (ev_up),
        .ev_dn  (ev_dn),
        .pwm    (pwm_out)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_PRD: reg_rdata = prd_q;
            ADDR_CMP: reg_rdata = cmp_shd;
            ADDR_ACT: reg_rdata = act_q;
            default:  reg_rdata = mode_q;
        endcase
        cnt_out = cnt;
    end

endmodule

// File: rtl/pwm_cmp_chk.sv
`timescale 1ns/1ps
module pwm_cmp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         dir_up,
    input logic [W-1:0] prd,
    input logic [W-1:0] act_cmp,
    input logic [W-1:0] shd_cmp,
    input logic         zero_only,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic         pwm
);
    localparam logic [W-1:0] ONE = W'(1);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE) || (cnt == $past(cnt))); // R2

    AST_TURN_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up && (cnt == prd) && (prd != '0)) |=> !dir_up); // R2

    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp != $past(act_cmp)) |-> (($past(cnt) == '0) || (($past(cnt) == $past(prd)) && !$past(zero_only)))); // R5

    AST_NO_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_only && (cnt == prd) && (cnt != '0)) |=> (act_cmp == $past(act_cmp))); // R6

    AST_PIN_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm != $past(pwm)) |-> $past((cnt == '0) || (cnt == prd) ||
                                     ((cnt == act_cmp) && (act_cmp != '0) && (act_cmp < prd)))); // R9

    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd1)) |=> (shd_cmp == $past(reg_wdata))); // R10

endmodule

bind pwm_cmp_unit pwm_cmp_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .dir_up   (dir_up),
    .prd      (prd_q),
    .act_cmp  (cmp_act),
    .shd_cmp  (cmp_shd),
    .zero_only(mode_q[0]),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .pwm      (pwm_out)
);

// File: tb/tb_pwm_cmp_unit.sv
`timescale 1ns/1ps
module tb_pwm_cmp_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata, cnt_out;
    logic         dir_up, pwm_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_cmp_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_out(cnt_out),
        .dir_up(dir_up), .pwm_out(pwm_out)
    );

    // {period, compare, action word, mode, expected high clocks over 4 cycles}
    localparam logic [79:0] VEC [7] = '{
        {16'd10, 16'd4,  16'h0090, 16'd0, 16'd32},
        {16'd10, 16'd4,  16'h0060, 16'd0, 16'd48},
        {16'd16, 16'd5,  16'h0090, 16'd1, 16'd40},
        {16'd10, 16'd0,  16'h0006, 16'd0, 16'd40},
        {16'd10, 16'd4,  16'h0050, 16'd0, 16'd0},
        {16'd20, 16'd15, 16'h0090, 16'd0, 16'd120},
        {16'd6,  16'd1,  16'h0090, 16'd0, 16'd8}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cnt(input int v, input bit up);
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (cnt_out == W'(v) && dir_up == up) break;
        end
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (pwm_out) break;
        end
        for (int k = 0; k < 1000; k++) begin
            if (!pwm_out) break;
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int hi, w, mx, zc, tg;
        logic prev;

        // R1 reset state
        do_reset();
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 pin", int'(pwm_out), 0);
        check(cnt_out == '0, "R1 count", int'(cnt_out), 0);
        check(dir_up == 1'b1, "R1 direction", int'(dir_up), 1);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            check(reg_rdata == '0, "R1 register", int'(reg_rdata), 0);
        end

        // R2 period 0 holds
        repeat (5) @(negedge clk);
        check(cnt_out == '0, "R2 zero period", int'(cnt_out), 0);

        // vector table: R3 R4 duty patterns
        for (int i = 0; i < 7; i++) begin
            wr(2'd3, VEC[i][31:16]);
            wr(2'd1, VEC[i][63:48]);
            wr(2'd2, VEC[i][47:32]);
            wr(2'd0, VEC[i][79:64]);
            repeat (100) @(negedge clk);
            hi = 0;
            for (int k = 0; k < 8 * int'(VEC[i][79:64]); k++) begin
                @(negedge clk);
                hi += int'(pwm_out);
            end
            check(hi == int'(VEC[i][15:0]), "R3/R4 duty vector", hi, int'(VEC[i][15:0]));
        end

        // R2 triangle shape
        do_reset();
        wr(2'd0, 16'd10);
        mx = 0; zc = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (int'(cnt_out) > mx) mx = int'(cnt_out);
            if (cnt_out == '0) zc++;
        end
        check(mx == 10, "R2 peak", mx, 10);
        check(zc == 2, "R2 zero visits per 40 clocks", zc, 2);

        // R10 readback returns shadow
        wr(2'd1, 16'd123);
        reg_addr = 2'd1; #1;
        check(reg_rdata == 16'd123, "R10 compare shadow read", int'(reg_rdata), 123);
        reg_addr = 2'd0; #1;
        check(reg_rdata == 16'd10, "R10 period read", int'(reg_rdata), 10);

        // R5 normal mode: compare written before period boundary used at once
        do_reset();
        wr(2'd1, 16'd4); wr(2'd2, 16'h0090); wr(2'd0, 16'd10);
        repeat (60) @(negedge clk);
        wait_cnt(8, 1'b1);
        wr(2'd1, 16'd6);
        pulse_width(w);
        check(w == 12, "R5 pulse after period load", w, 12);

        // R6 R7 zero-only mode with action word rewritten: partial first pulse
        do_reset();
        wr(2'd3, 16'd1); wr(2'd1, 16'd4); wr(2'd2, 16'h0050); wr(2'd0, 16'd10);
        repeat (60) @(negedge clk);
        wait_cnt(8, 1'b1);
        wr(2'd2, 16'h0090);
        wr(2'd1, 16'd6);
        for (int k = 0; k < 100; k++) begin
            if (pwm_out) break;
            @(negedge clk);
        end
        check(cnt_out == 16'd3 && !dir_up, "R7 first rise in same cycle", int'(cnt_out), 3);
        w = 0;
        for (int k = 0; k < 100; k++) begin
            if (!pwm_out) break;
            w++;
            @(negedge clk);
        end
        check(w == 10, "R6 partial first pulse", w, 10);
        pulse_width(w);
        check(w == 12, "R6 following pulse", w, 12);

        // R8 coincident zero and period at period 0
        do_reset();
        wr(2'd2, 16'h0002);
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b1, "R8 zero set alone", int'(pwm_out), 1);
        wr(2'd2, 16'h0006);
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b0, "R8 period clear beats zero set", int'(pwm_out), 0);
        wr(2'd2, 16'h0009);
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b1, "R8 period set beats zero clear", int'(pwm_out), 1);

        // R9 out-of-range compare holds level
        do_reset();
        wr(2'd1, 16'd4); wr(2'd2, 16'h0090); wr(2'd0, 16'd10);
        repeat (60) @(negedge clk);
        wait_cnt(2, 1'b0);
        wr(2'd1, 16'd10);
        prev = pwm_out; tg = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (pwm_out != prev) tg++;
            prev = pwm_out;
        end
        check(tg == 0 && pwm_out, "R9 compare equal to period", tg, 0);
        wr(2'd1, 16'd0);
        tg = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (pwm_out != prev) tg++;
            prev = pwm_out;
        end
        check(tg == 0 && pwm_out, "R9 compare zero", tg, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule